// File: doc/BRIEF.md
# Region-Keyed Hold Register Scrambler

This block keeps a 16-bit hold value that moves forward one step each time an update strobe is seen. A step rotates the value left by one place, flips a fixed pattern into it, and then folds in three things: a single bit chosen from an incoming data byte, a 4-bit key, and feedback taken from the old value. A 2-bit region code decides which old bits are fed back and where two of the key bits land. Because the whole value depends on the order of the steps, the hold value works as a running signature of a sequence of writes.

A synchronous clear returns the value to zero. An 8-bit scrambled view of the value is available combinationally, so surrounding logic can read it back. Decoding of the bus and the derivation of the key are left to the caller.

Top module: `region_hold_scrambler`

## Requirements
- R1: After reset, `hold_o` is 0x0000 and `view_o` is 0x00.
- R2: An update rotates the old value left by one (old bit 15 goes to bit 0) and XORs in 0x2BAD. From zero with all other inputs zero, one update in region 0 gives 0x2BAD.
- R3: On an update, bit `sel_i` of `byte_i` (bit 0 = LSB) is XORed into bit 0 of the new value, and so is old bit 5, in every region.
- R4: In every region, `key_i[1]` is XORed into new bit 6 and `key_i[2]` into new bit 10.
- R5: With `region_i` = 0 or 1, old bits 10 and 8 are XORed into new bit 0, `key_i[0]` into bit 1 and `key_i[3]` into bit 14.
- R6: With `region_i` = 2, old bits 10 and 8 are XORed into new bit 0, `key_i[0]` into bit 4 and `key_i[3]` into bit 12.
- R7: With `region_i` = 3, old bits 7 and 6 are XORed into new bit 0, `key_i[0]` into bit 4 and `key_i[3]` into bit 12.
- R8: `view_o` bits 0 through 7 are hold bits 15, 12, 13, 10, 7, 9, 2, 5 in that order, with no clock delay. For 0x2BAD the view is 0xF4.
- R9: A clock edge with `clr_i` high sets the hold value to 0x0000.
- R10: When `clr_i` and `upd_i` are high on the same edge, the clear takes effect and the update is dropped.
- R11: On an edge with neither `upd_i` nor `clr_i` high, the hold value does not change, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | Update strobe, one step per high cycle |
| clr_i | input | 1 | Synchronous clear of the hold value |
| region_i | input | 2 | Region code, sampled on the update edge |
| key_i | input | 4 | Key bits mixed into the update |
| sel_i | input | 3 | Index of the data bit to mix in |
| byte_i | input | 8 | Data byte supplying the selected bit |
| hold_o | output | 16 | Current hold value |
| view_o | output | 8 | Permuted 8-bit view of the hold value |

## Verification
The clear and the update are the two functions that can fall on the same edge. The bench drives both strobes high together from a nonzero hold value, with keys and data that would change the value if the step were taken, and expects the value to read zero on the next cycle. A reference model in the bench steps alongside the design for long runs of random inputs across all four regions, and compares the hold value and the view after every edge.

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam int STATE_W = 16;
    localparam int VIEW_W  = 8;
    localparam logic [STATE_W-1:0] MIX_CONST = 16'h2BAD;

    typedef enum logic [1:0] {
        RGN_A = 2'd0,
        RGN_B = 2'd1,
        RGN_C = 2'd2,
        RGN_D = 2'd3
    } region_e;

    typedef struct packed {
        logic [STATE_W-1:0] hold;
    } scr_state_t;

    function automatic int view_src(input int idx);
        case (idx)
            0: return 15;
            1: return 12;
            2: return 13;
            3: return 10;
            4: return 7;
            5: return 9;
            6: return 2;
            default: return 5;
        endcase
    endfunction
endpackage

// File: rtl/scr_next.sv
module scr_next
    import scr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int KEY_W  = 4,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic [STATE_W-1:0] old_i,
    input  logic [1:0]         region_i,
    input  logic [KEY_W-1:0]   key_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [DATA_W-1:0]  byte_i,
    output logic [STATE_W-1:0] nxt_o
);
    logic [STATE_W-1:0] rot_d;
    logic               fb_d;
    logic               data_bit_d;
    region_e            rgn_d;

    always_comb begin
        rgn_d      = region_e'(region_i);
        rot_d      = {old_i[STATE_W-2:0], old_i[STATE_W-1]};
        data_bit_d = byte_i[sel_i];
        if (rgn_d == RGN_D) fb_d = old_i[7] ^ old_i[6];
        else                fb_d = old_i[10] ^ old_i[8];

        nxt_o      = rot_d ^ MIX_CONST;
        nxt_o[0]   = nxt_o[0] ^ data_bit_d ^ old_i[5] ^ fb_d;
        nxt_o[6]   = nxt_o[6] ^ key_i[1];
        nxt_o[10]  = nxt_o[10] ^ key_i[2];
        case (rgn_d)
            RGN_A, RGN_B: begin
                nxt_o[1]  = nxt_o[1] ^ key_i[0];
                nxt_o[14] = nxt_o[14] ^ key_i[3];
            end
            default: begin
                nxt_o[4]  = nxt_o[4] ^ key_i[0];
                nxt_o[12] = nxt_o[12] ^ key_i[3];
            end
        endcase
    end
endmodule

// File: rtl/scr_view.sv
module scr_view
    import scr_pkg::*;
(
    input  logic [STATE_W-1:0] hold_i,
    output logic [VIEW_W-1:0]  view_o
);
    for (genvar g = 0; g < VIEW_W; g++) begin : g_pick
        assign view_o[g] = hold_i[view_src(g)];
    end
endmodule

// File: rtl/region_hold_scrambler.sv
module region_hold_scrambler
    import scr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int KEY_W  = 4,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_i,
    input  logic               clr_i,
    input  logic [1:0]         region_i,
    input  logic [KEY_W-1:0]   key_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [DATA_W-1:0]  byte_i,
    output logic [STATE_W-1:0] hold_o,
    output logic [VIEW_W-1:0]  view_o
);
    scr_state_t         st_d, st_q;
    logic [STATE_W-1:0] step_d;

    scr_next #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_next (
        .old_i    (st_q.hold),
        .region_i (region_i),
        .key_i    (key_i),
        .sel_i    (sel_i),
        .byte_i   (byte_i),
        .nxt_o    (step_d)
    );

    scr_view u_view (
        .hold_i (st_q.hold),
        .view_o (view_o)
    );

    always_comb begin
        st_d = st_q;
        if (clr_i)      st_d.hold = '0;
        else if (upd_i) st_d.hold = step_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o = st_q.hold;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (hold_o == '0)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !upd_i) |=> $stable(hold_o)); // R11
    AST_ROT_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !clr_i) |=> (hold_o[9] == ($past(hold_o[8]) ^ MIX_CONST[9]))); // R2
    AST_LOW_KEY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !clr_i && region_i[1]) |=> (hold_o[1] == ($past(hold_o[0]) ^ MIX_CONST[1]))); // R7
    AST_HIGH_KEY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !clr_i && !region_i[1]) |=> (hold_o[4] == ($past(hold_o[3]) ^ MIX_CONST[4]))); // R5
    AST_VIEW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (view_o[0] == hold_o[15]) && (view_o[7] == hold_o[5])); // R8
endmodule

// File: tb/region_hold_scrambler_tb.sv
module region_hold_scrambler_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_i = 1'b0;
    logic        clr_i = 1'b0;
    logic [1:0]  region_i = '0;
    logic [3:0]  key_i = '0;
    logic [2:0]  sel_i = '0;
    logic [7:0]  byte_i = '0;
    logic [15:0] hold_o;
    logic [7:0]  view_o;

    int n_chk = 0;
    int n_bad = 0;
    int model = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    region_hold_scrambler u_dut (
        .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .clr_i(clr_i),
        .region_i(region_i), .key_i(key_i), .sel_i(sel_i), .byte_i(byte_i),
        .hold_o(hold_o), .view_o(view_o)
    );

    function automatic int bitof(int v, int b);
        return (v >> b) & 1;
    endfunction

    // Reference step written from the requirements.
    function automatic int ref_step(int s, int r, int k, int b, int sl);
        int n;
        int taps;
        n = ((s << 1) | (s >> 15)) & 16'hFFFF;
        n = n ^ 16'h2BAD;
        taps = bitof(b, sl) ^ bitof(s, 5);
        if (r == 3) taps = taps ^ bitof(s, 7) ^ bitof(s, 6);
        else        taps = taps ^ bitof(s, 10) ^ bitof(s, 8);
        n = n ^ taps ^ (bitof(k, 1) << 6) ^ (bitof(k, 2) << 10);
        if (r < 2) n = n ^ (bitof(k, 0) << 1) ^ (bitof(k, 3) << 14);
        else       n = n ^ (bitof(k, 0) << 4) ^ (bitof(k, 3) << 12);
        return n;
    endfunction

    function automatic int ref_view(int s);
        int order[8] = '{15, 12, 13, 10, 7, 9, 2, 5};
        int v = 0;
        foreach (order[i]) v = v | (bitof(s, order[i]) << i);
        return v;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, advance the model, compare after the edge.
    task automatic cyc(string req, bit u, bit c, int r, int k, int s, int b);
        @(negedge clk);
        upd_i = u; clr_i = c; region_i = 2'(r); key_i = 4'(k);
        sel_i = 3'(s); byte_i = 8'(b);
        if (c)      model = 0;
        else if (u) model = ref_step(model, r, k, b, s);
        @(negedge clk);
        upd_i = 1'b0; clr_i = 1'b0;
        chk(req, int'(hold_o), model);
        chk("R8", int'(view_o), ref_view(model));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", int'(hold_o), 0);
        chk("R1", int'(view_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: first step from zero gives the constant; view literal for R8
        cyc("R2", 1, 0, 0, 0, 0, 0);
        chk("R2", int'(hold_o), 16'h2BAD);
        chk("R8", int'(view_o), 8'hF4);
        // R3: data bit selection
        cyc("R3", 1, 0, 1, 0, 6, 8'h40);
        cyc("R3", 1, 0, 2, 0, 6, 8'hBF);
        cyc("R3", 1, 0, 3, 0, 0, 8'h01);
        // R4: common key bits
        cyc("R4", 1, 0, 0, 4'b0110, 0, 0);
        cyc("R4", 1, 0, 3, 4'b0110, 0, 0);
        // R5, R6, R7: region placement of key bits 0 and 3
        cyc("R5", 1, 0, 0, 4'b1001, 2, 8'h55);
        cyc("R5", 1, 0, 1, 4'b1001, 3, 8'hAA);
        cyc("R6", 1, 0, 2, 4'b1001, 4, 8'h0F);
        cyc("R7", 1, 0, 3, 4'b1001, 5, 8'hF0);
        // R11: idle edges with busy inputs
        cyc("R11", 0, 0, 3, 4'hF, 7, 8'hFF);
        cyc("R11", 0, 0, 1, 4'h5, 2, 8'h12);
        // R10: clear and update together from a nonzero value
        cyc("R10", 1, 1, 2, 4'hF, 1, 8'hFF);
        chk("R10", int'(hold_o), 0);
        // R9: plain clear after some steps
        cyc("R6", 1, 0, 2, 4'hA, 3, 8'h3C);
        cyc("R7", 1, 0, 3, 4'h5, 1, 8'hC3);
        cyc("R9", 0, 1, 0, 4'h3, 0, 8'h00);
        chk("R9", int'(hold_o), 0);
        // Long random run across all regions
        for (int i = 0; i < 2000; i++) begin
            int r = int'($urandom_range(3, 0));
            int roll = int'($urandom_range(31, 0));
            bit u = (roll != 0) && (roll != 1);
            bit c = (roll == 0);
            string tag = (r < 2) ? "R5" : ((r == 2) ? "R6" : "R7");
            if (!u && !c) tag = "R11";
            if (c) tag = "R9";
            cyc(tag, u, c, r, int'($urandom_range(15, 0)),
                int'($urandom_range(7, 0)), int'($urandom_range(255, 0)));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule